// File: doc/BRIEF.md
# Decoded Micro-op Cache

This block keeps micro-ops that the decoders have already produced, so that a front end can replay them without decoding the same bytes again. Code is divided into aligned 32-byte regions. Every region maps to one set of a set-associative array, and each way in that set holds a short run of micro-ops, not instruction bytes. A fill port accepts decoded micro-ops one per cycle. Each one carries its instruction address and a flag that marks an unconditional branch. The fill logic packs the micro-ops into ways under fixed rules: a way holds at most six micro-ops, an unconditional branch closes its way, a region may own at most three ways, and a region that needs more is dropped as a whole.

A lookup port takes a fetch address. One cycle after the lookup is accepted it reports hit or miss, together with up to four micro-ops in program order. The micro-ops start at the one whose instruction address equals the fetch address and run on across the region's ways in address order. Delivery stops after an unconditional branch. Victim ways are picked by a tree pseudo-LRU per set, and evicting any way of a region removes the whole region. A flush input empties the cache in one cycle.

Top module: `uop_cache`

## Requirements
- R1: After reset, and on the cycle after `flush` is high for one cycle, every lookup reports a miss (`rsp_hit`=0, `rsp_cnt`=0).
- R2: A lookup accepted at a clock edge gives `rsp_valid`=1 after that edge. On a hit, `rsp_uops` holds up to four micro-ops in program order, with the oldest in bits [15:0], and `rsp_cnt` gives how many there are.
- R3: A lookup misses when its fetch address is not the start address of any cached micro-op in its region. An offset in the middle of an instruction is one such case.
- R4: A way holds at most six micro-ops, so the seventh micro-op of a region opens a new way. Delivery continues across the way boundary in address order.
- R5: An unconditional branch is the last micro-op of its way, and the next micro-op of the region opens a new way. Delivery ends with the branch.
- R6: A region whose fill would need a fourth way is invalidated as a whole, and all later lookups into it miss.
- R7: A region of exactly 18 micro-ops, held in three full ways, is cached completely and hits at any of its micro-op addresses.
- R8: The set index is address bits [9:5] and the tag is bits [31:10]. Regions that differ only in tag coexist in one set.
- R9: When a set is full, the victim is the way picked by the pseudo-LRU. Evicting any way of a region invalidates all ways of that region.
- R10: Ways that are free are allocated before any valid way is evicted.
- R11: While a fill targets the same set as the lookup address, `lookup_ready` is 0. For a different set it is 1, and both operations proceed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate every way |
| fill_valid | input | 1 | A decoded micro-op is presented |
| fill_addr | input | 32 | Instruction address of the micro-op |
| fill_uop | input | 16 | Micro-op payload |
| fill_ubr | input | 1 | Micro-op is an unconditional branch |
| lookup_valid | input | 1 | Lookup requested |
| lookup_addr | input | 32 | Fetch address |
| lookup_ready | output | 1 | Lookup accepted this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Fetch address found |
| rsp_cnt | output | 3 | Number of delivered micro-ops (0 to 4) |
| rsp_uops | output | 64 | Delivered micro-ops, oldest in bits [15:0] |

## Verification
A fill micro-op presented before an edge is stored at that edge, and a lookup accepted at the next edge can already see it. Each lookup response appears on the edge that accepts the lookup and lasts one cycle. `lookup_ready` is combinational on the current fill and lookup addresses. The bench therefore changes inputs on falling edges and checks each response at the falling edge right after the accepting rising edge. It checks `lookup_ready` a moment after setting the addresses, inside the same cycle.

// File: rtl/uc_pkg.sv
// Shared sizes and types for the decoded micro-op cache.
// Assumes power-of-two set count, way count and region size.
package uc_pkg;
    parameter int ADDR_W   = 32;
    parameter int UOP_W    = 16;
    parameter int SETS     = 32;
    parameter int WAYS     = 8;
    parameter int SLOTS    = 6;
    parameter int REG_WAYS = 3;
    parameter int DELIVER  = 4;
    parameter int REGION_B = 32;

    localparam int OFF_W  = $clog2(REGION_B);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int RCNT_W = $clog2(REG_WAYS + 1);
    localparam int DCNT_W = $clog2(DELIVER + 1);
    localparam int FLAT   = REG_WAYS * SLOTS;

    typedef struct packed {
        logic [UOP_W-1:0] uop;
        logic [OFF_W-1:0] off;
        logic             ubr;
    } slot_t;
endpackage

// File: rtl/uc_plru.sv
// Tree pseudo-LRU state, one tree per set.
// Gives the victim for one set and takes up to two touches per cycle.
// Assumes the two touches target different sets; if not, touch A wins.
module uc_plru
    import uc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim,
    input  logic             ta_en,
    input  logic [SET_W-1:0] ta_set,
    input  logic [WAY_W-1:0] ta_way,
    input  logic             tb_en,
    input  logic [SET_W-1:0] tb_set,
    input  logic [WAY_W-1:0] tb_way
);
    logic [WAYS-2:0] tree [SETS];

    // Point every node on the path of way w away from it.
    function automatic logic [WAYS-2:0] touch(input logic [WAYS-2:0] t, input logic [WAY_W-1:0] w);
        int n;
        int p;
        n = WAYS + int'(w);
        for (int lv = 0; lv < WAY_W; lv++) begin
            p = n / 2;
            t[p-1] = (n % 2 == 0);
            n = p;
        end
        return t;
    endfunction

    // Walk the tree of the read set down to the victim leaf.
    always_comb begin
        int n;
        n = 1;
        for (int lv = 0; lv < WAY_W; lv++)
            n = 2 * n + int'(tree[rd_set][n-1]);
        victim = WAY_W'(n - WAYS);
    end

    // Update the trees on allocation and on lookup hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree[s] <= '0;
        end else begin
            if (ta_en) tree[ta_set] <= touch(tree[ta_set], ta_way);
            if (tb_en && !(ta_en && ta_set == tb_set))
                tree[tb_set] <= touch(tree[tb_set], tb_way);
        end
    end
endmodule

// File: rtl/uc_fill_ctl.sv
// Packing engine for the fill stream.
// Decides per micro-op whether to append, open a way, or drop the region,
// and which tags to invalidate. Assumes micro-ops of one region arrive
// in ascending address order; a lower address starts a fresh region fill.
module uc_fill_ctl
    import uc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] f_set,
    input  logic [TAG_W-1:0] f_tag,
    input  logic [OFF_W-1:0] f_off,
    input  logic             fill_ubr,
    input  logic [WAYS-1:0]  set_v,
    input  logic [TAG_W-1:0] set_tag [WAYS],
    input  logic [WAY_W-1:0] plru_victim,
    output logic             wr_en,
    output logic             wr_new,
    output logic [WAY_W-1:0] wr_way,
    output logic [CNT_W-1:0] wr_slot,
    output logic             kill_a_en,
    output logic [TAG_W-1:0] kill_a_tag,
    output logic             kill_b_en,
    output logic [TAG_W-1:0] kill_b_tag
);
    logic              act, broken, prev_ubr;
    logic [SET_W-1:0]  cur_set;
    logic [TAG_W-1:0]  cur_tag;
    logic [WAY_W-1:0]  cur_way;
    logic [CNT_W-1:0]  cur_cnt;
    logic [RCNT_W-1:0] used;
    logic [OFF_W-1:0]  prev_off;

    logic fv, new_reg, need_way, ovf, alloc, append;
    logic [WAYS-1:0]  own, free;
    logic [WAY_W-1:0] pick;

    // Classify the incoming micro-op against the region being filled.
    always_comb begin
        fv       = fill_valid && !flush;
        new_reg  = !act || f_set != cur_set || f_tag != cur_tag || f_off < prev_off;
        need_way = new_reg || (!broken && (cur_cnt == CNT_W'(SLOTS) || prev_ubr));
        ovf      = !new_reg && need_way && used == RCNT_W'(REG_WAYS);
        alloc    = fv && need_way && !ovf;
        append   = fv && !new_reg && !broken && !need_way;
    end

    // Choose the way to open: free first, then pseudo-LRU, never an own way.
    always_comb begin
        logic got;
        for (int w = 0; w < WAYS; w++) begin
            own[w]  = set_v[w] && set_tag[w] == f_tag;
            free[w] = !set_v[w] || (new_reg && own[w]);
        end
        pick = '0;
        got  = 1'b0;
        for (int w = 0; w < WAYS; w++)
            if (!got && free[w]) begin
                pick = WAY_W'(w);
                got  = 1'b1;
            end
        if (!got && !own[plru_victim]) begin
            pick = plru_victim;
            got  = 1'b1;
        end
        for (int w = 0; w < WAYS; w++)
            if (!got && !own[w]) begin
                pick = WAY_W'(w);
                got  = 1'b1;
            end
    end

    // Drive the array write and invalidation requests.
    always_comb begin
        wr_en      = alloc || append;
        wr_new     = alloc;
        wr_way     = alloc ? pick : cur_way;
        wr_slot    = alloc ? '0 : cur_cnt;
        kill_a_en  = fv && (new_reg || ovf);
        kill_a_tag = f_tag;
        kill_b_en  = alloc && !free[pick];
        kill_b_tag = set_tag[pick];
    end

    // Track the region fill in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            act      <= 1'b0;
            broken   <= 1'b0;
            prev_ubr <= 1'b0;
            cur_set  <= '0;
            cur_tag  <= '0;
            cur_way  <= '0;
            cur_cnt  <= '0;
            used     <= '0;
            prev_off <= '0;
        end else if (fv) begin
            prev_ubr <= fill_ubr;
            prev_off <= f_off;
            if (new_reg) begin
                act     <= 1'b1;
                broken  <= 1'b0;
                cur_set <= f_set;
                cur_tag <= f_tag;
                cur_way <= pick;
                cur_cnt <= CNT_W'(1);
                used    <= RCNT_W'(1);
            end else if (ovf) begin
                broken <= 1'b1;
            end else if (alloc) begin
                cur_way <= pick;
                cur_cnt <= CNT_W'(1);
                used    <= used + RCNT_W'(1);
            end else if (append) begin
                cur_cnt <= cur_cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/uc_lookup.sv
// Combinational lookup within one set.
// Chains the region's ways by start offset, finds the first micro-op whose
// address equals the fetch offset, and gathers up to DELIVER micro-ops,
// stopping after an unconditional branch.
module uc_lookup
    import uc_pkg::*;
(
    input  logic [TAG_W-1:0]         l_tag,
    input  logic [OFF_W-1:0]         l_off,
    input  logic [WAYS-1:0]          set_v,
    input  logic [TAG_W-1:0]         set_tag [WAYS],
    input  logic [CNT_W-1:0]         set_cnt [WAYS],
    input  slot_t                    set_slot [WAYS][SLOTS],
    output logic                     hit,
    output logic [DCNT_W-1:0]        cnt,
    output logic [DELIVER*UOP_W-1:0] uops,
    output logic [WAY_W-1:0]         hit_way
);
    logic [WAYS-1:0]  m;
    int               rank [WAYS];
    logic [FLAT-1:0]  fv;
    slot_t            fs [FLAT];
    logic [WAY_W-1:0] fw [FLAT];

    // Rank matching ways by start offset and lay them out in order.
    always_comb begin
        for (int w = 0; w < WAYS; w++)
            m[w] = set_v[w] && set_tag[w] == l_tag;
        for (int w = 0; w < WAYS; w++) begin
            rank[w] = 0;
            for (int v = 0; v < WAYS; v++)
                if (m[v] && set_slot[v][0].off < set_slot[w][0].off) rank[w]++;
        end
        fv = '0;
        for (int p = 0; p < FLAT; p++) begin
            fs[p] = '0;
            fw[p] = '0;
        end
        for (int w = 0; w < WAYS; w++)
            for (int i = 0; i < SLOTS; i++)
                if (m[w] && rank[w] < REG_WAYS && i < int'(set_cnt[w])) begin
                    fv[rank[w]*SLOTS + i] = 1'b1;
                    fs[rank[w]*SLOTS + i] = set_slot[w][i];
                    fw[rank[w]*SLOTS + i] = WAY_W'(w);
                end
    end

    // Locate the entry point and gather the delivered micro-ops.
    always_comb begin
        int   hp;
        int   k;
        logic stop;
        hit     = 1'b0;
        hit_way = '0;
        hp      = 0;
        for (int p = 0; p < FLAT; p++)
            if (!hit && fv[p] && fs[p].off == l_off) begin
                hit     = 1'b1;
                hp      = p;
                hit_way = fw[p];
            end
        k    = 0;
        stop = 1'b0;
        uops = '0;
        for (int p = 0; p < FLAT; p++)
            if (hit && p >= hp && fv[p] && !stop && k < DELIVER) begin
                uops[k*UOP_W +: UOP_W] = fs[p].uop;
                k++;
                if (fs[p].ubr) stop = 1'b1;
            end
        cnt = DCNT_W'(k);
    end
endmodule

// File: rtl/uop_cache.sv
// Decoded micro-op cache top: arrays, valid bits and response register.
// Fill has priority over a lookup into the same set; flush clears all
// valid bits in one cycle and blocks both ports for that cycle.
module uop_cache
    import uc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     fill_valid,
    input  logic [ADDR_W-1:0]        fill_addr,
    input  logic [UOP_W-1:0]         fill_uop,
    input  logic                     fill_ubr,
    input  logic                     lookup_valid,
    input  logic [ADDR_W-1:0]        lookup_addr,
    output logic                     lookup_ready,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [DCNT_W-1:0]        rsp_cnt,
    output logic [DELIVER*UOP_W-1:0] rsp_uops
);
    logic [WAYS-1:0]  way_v   [SETS];
    logic [TAG_W-1:0] way_tag [SETS][WAYS];
    logic [CNT_W-1:0] way_cnt [SETS][WAYS];
    slot_t            way_slot [SETS][WAYS][SLOTS];

    logic [SET_W-1:0] f_set, l_set;
    logic [TAG_W-1:0] f_tag, l_tag;
    logic [OFF_W-1:0] f_off, l_off;

    logic [TAG_W-1:0] fset_tag [WAYS];
    logic [TAG_W-1:0] lset_tag [WAYS];
    logic [CNT_W-1:0] lset_cnt [WAYS];
    slot_t            lset_slot [WAYS][SLOTS];

    logic             wr_en, wr_new, kill_a_en, kill_b_en;
    logic [WAY_W-1:0] wr_way, plru_victim, lk_way;
    logic [CNT_W-1:0] wr_slot;
    logic [TAG_W-1:0] kill_a_tag, kill_b_tag;
    logic             lk_hit, accept;
    logic [DCNT_W-1:0]        lk_cnt;
    logic [DELIVER*UOP_W-1:0] lk_uops;
    logic [WAYS-1:0]          nv;
    logic [SETS*WAYS-1:0]     valid_flat;

    // Split both addresses into tag, set and offset.
    always_comb begin
        f_off = fill_addr[OFF_W-1:0];
        f_set = fill_addr[OFF_W +: SET_W];
        f_tag = fill_addr[ADDR_W-1 -: TAG_W];
        l_off = lookup_addr[OFF_W-1:0];
        l_set = lookup_addr[OFF_W +: SET_W];
        l_tag = lookup_addr[ADDR_W-1 -: TAG_W];
        lookup_ready = !flush && !(fill_valid && f_set == l_set);
        accept = lookup_valid && lookup_ready;
    end

    // Present the fill set and the lookup set to their engines.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            fset_tag[w] = way_tag[f_set][w];
            lset_tag[w] = way_tag[l_set][w];
            lset_cnt[w] = way_cnt[l_set][w];
            for (int i = 0; i < SLOTS; i++) lset_slot[w][i] = way_slot[l_set][w][i];
        end
    end

    uc_fill_ctl u_fill (
        .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
        .f_set(f_set), .f_tag(f_tag), .f_off(f_off), .fill_ubr(fill_ubr),
        .set_v(way_v[f_set]), .set_tag(fset_tag), .plru_victim(plru_victim),
        .wr_en(wr_en), .wr_new(wr_new), .wr_way(wr_way), .wr_slot(wr_slot),
        .kill_a_en(kill_a_en), .kill_a_tag(kill_a_tag),
        .kill_b_en(kill_b_en), .kill_b_tag(kill_b_tag)
    );

    uc_lookup u_lookup (
        .l_tag(l_tag), .l_off(l_off), .set_v(way_v[l_set]), .set_tag(lset_tag),
        .set_cnt(lset_cnt), .set_slot(lset_slot),
        .hit(lk_hit), .cnt(lk_cnt), .uops(lk_uops), .hit_way(lk_way)
    );

    uc_plru u_plru (
        .clk(clk), .rst_n(rst_n), .rd_set(f_set), .victim(plru_victim),
        .ta_en(wr_en && wr_new), .ta_set(f_set), .ta_way(wr_way),
        .tb_en(accept && lk_hit), .tb_set(l_set), .tb_way(lk_way)
    );

    // Next valid vector of the fill set: invalidations, then the new way.
    always_comb begin
        nv = way_v[f_set];
        for (int w = 0; w < WAYS; w++) begin
            if (kill_a_en && way_tag[f_set][w] == kill_a_tag) nv[w] = 1'b0;
            if (kill_b_en && way_tag[f_set][w] == kill_b_tag) nv[w] = 1'b0;
            if (wr_en && wr_new && wr_way == WAY_W'(w)) nv[w] = 1'b1;
        end
        for (int s = 0; s < SETS; s++) valid_flat[s*WAYS +: WAYS] = way_v[s];
    end

    // Valid bits: cleared by reset or flush, updated by fills.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int s = 0; s < SETS; s++) way_v[s] <= '0;
        end else if (fill_valid) begin
            way_v[f_set] <= nv;
        end
    end

    // Way contents: tag, count and micro-op slots.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_new) way_tag[f_set][wr_way] <= f_tag;
            way_cnt[f_set][wr_way]           <= wr_slot + CNT_W'(1);
            way_slot[f_set][wr_way][wr_slot] <= '{uop: fill_uop, off: f_off, ubr: fill_ubr};
        end
    end

    // Register the lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_cnt   <= '0;
            rsp_uops  <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && lk_hit;
            rsp_cnt   <= accept ? lk_cnt : '0;
            rsp_uops  <= accept ? lk_uops : '0;
        end
    end
endmodule

// File: rtl/uop_cache_chk.sv
// Protocol and state checks for the decoded micro-op cache.
module uop_cache_chk
    import uc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic                 lookup_valid,
    input logic                 lookup_ready,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic [DCNT_W-1:0]    rsp_cnt,
    input logic [SETS*WAYS-1:0] valid_flat,
    input logic                 wr_en,
    input logic [CNT_W-1:0]     wr_slot
);
    // R2
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && lookup_ready) |=> rsp_valid);
    // R2
    rsp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ? (rsp_cnt != 0 && rsp_cnt <= DCNT_W'(DELIVER)) : rsp_cnt == 0));
    // R1
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> valid_flat == '0);
    // R4
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_slot < CNT_W'(SLOTS));
    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_ready |=> !rsp_valid);
endmodule

bind uop_cache uop_cache_chk u_chk (.*);

// File: tb/uop_cache_tb.sv
`timescale 1ns/100ps
module uop_cache_tb;
    import uc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [UOP_W-1:0] fill_uop = '0;
    logic fill_ubr = 1'b0;
    logic lookup_valid = 1'b0;
    logic [ADDR_W-1:0] lookup_addr = '0;
    logic lookup_ready, rsp_valid, rsp_hit;
    logic [DCNT_W-1:0] rsp_cnt;
    logic [DELIVER*UOP_W-1:0] rsp_uops;

    int n_chk = 0;
    int n_bad = 0;

    uop_cache u_dut (.*);

    always #2.5 clk = ~clk;

    function automatic logic [ADDR_W-1:0] mk(int tag, int set, int off);
        return {TAG_W'(tag), SET_W'(set), OFF_W'(off)};
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_run(int tag, int set, int off0, int step, int n, int base, int ubr_idx);
        for (int i = 0; i < n; i++) begin
            fill_valid = 1'b1;
            fill_addr  = mk(tag, set, off0 + i * step);
            fill_uop   = UOP_W'(base + i);
            fill_ubr   = (i == ubr_idx);
            @(negedge clk);
        end
        fill_valid = 1'b0;
        fill_ubr   = 1'b0;
        @(negedge clk);
    endtask

    task automatic look(string req, logic [ADDR_W-1:0] a, bit hit, int cnt, int first);
        lookup_valid = 1'b1;
        lookup_addr  = a;
        @(negedge clk);
        lookup_valid = 1'b0;
        check({req, " valid"}, rsp_valid, 1);
        check({req, " hit"}, rsp_hit, hit);
        check({req, " cnt"}, rsp_cnt, cnt);
        for (int k = 0; k < cnt; k++)
            check({req, " uop"}, rsp_uops[k*UOP_W +: UOP_W], first + k);
    endtask

    task automatic t_reset();
        check("R1 reset ready", lookup_ready, 1);
        check("R1 reset rsp_valid", rsp_valid, 0);
        look("R1 miss after reset", mk(1, 1, 0), 0, 0, 0);
    endtask

    task automatic t_basic();
        fill_run(1, 1, 0, 2, 5, 'h100, -1);
        look("R2 hit at region start", mk(1, 1, 0), 1, 4, 'h100);
        look("R2 hit mid region", mk(1, 1, 4), 1, 3, 'h102);
        look("R3 mid-instruction miss", mk(1, 1, 3), 0, 0, 0);
        look("R3 R8 other tag miss", mk(2, 1, 0), 0, 0, 0);
    endtask

    task automatic t_six();
        fill_run(1, 2, 0, 2, 7, 'h200, -1);
        look("R4 crossing into second way", mk(1, 2, 8), 1, 3, 'h204);
        look("R4 four across boundary", mk(1, 2, 6), 1, 4, 'h203);
    endtask

    task automatic t_branch();
        fill_run(1, 3, 0, 2, 4, 'h300, 1);
        look("R5 delivery stops at branch", mk(1, 3, 0), 1, 2, 'h300);
        look("R5 way after branch", mk(1, 3, 4), 1, 2, 'h302);
        fill_run(1, 4, 0, 1, 18, 'h400, 1);
        look("R5 R6 early close forces fourth way", mk(1, 4, 0), 0, 0, 0);
    endtask

    task automatic t_limits();
        fill_run(1, 5, 0, 1, 18, 'h500, -1);
        look("R7 full region start", mk(1, 5, 0), 1, 4, 'h500);
        look("R7 third way", mk(1, 5, 14), 1, 4, 'h50e);
        look("R7 last uop", mk(1, 5, 17), 1, 1, 'h511);
        fill_run(1, 6, 0, 1, 19, 'h600, -1);
        look("R6 overflow start miss", mk(1, 6, 0), 0, 0, 0);
        look("R6 overflow tail miss", mk(1, 6, 18), 0, 0, 0);
    endtask

    task automatic t_tags();
        fill_run(3, 1, 0, 2, 3, 'h130, -1);
        look("R8 second tag hit", mk(3, 1, 0), 1, 3, 'h130);
        look("R8 first tag kept", mk(1, 1, 0), 1, 4, 'h100);
    endtask

    task automatic t_replace();
        fill_run(1, 7, 0, 2, 8, 'h800, -1);
        for (int t = 2; t < 8; t++) fill_run(t, 7, 0, 2, 1, 'h800 + t * 16, -1);
        fill_run(8, 7, 0, 2, 1, 'h880, -1);
        look("R9 evicted region second way", mk(1, 7, 12), 0, 0, 0);
        look("R9 evicted region first way", mk(1, 7, 0), 0, 0, 0);
        look("R9 new region", mk(8, 7, 0), 1, 1, 'h880);
        look("R9 survivor", mk(2, 7, 0), 1, 1, 'h820);
        fill_run(9, 7, 0, 2, 1, 'h890, -1);
        look("R10 freed way reused", mk(9, 7, 0), 1, 1, 'h890);
        look("R10 no eviction B", mk(2, 7, 0), 1, 1, 'h820);
        look("R10 no eviction G", mk(7, 7, 0), 1, 1, 'h870);
        look("R10 no eviction H", mk(8, 7, 0), 1, 1, 'h880);
    endtask

    task automatic t_stall();
        fill_valid   = 1'b1;
        fill_addr    = mk(1, 9, 0);
        fill_uop     = 'h900;
        lookup_valid = 1'b1;
        lookup_addr  = mk(1, 9, 0);
        #1;
        check("R11 same set stalls", lookup_ready, 0);
        lookup_addr = mk(1, 10, 0);
        #1;
        check("R11 other set ready", lookup_ready, 1);
        @(negedge clk);
        fill_valid   = 1'b0;
        lookup_valid = 1'b0;
        check("R11 concurrent lookup answered", rsp_valid, 1);
        check("R11 concurrent lookup miss", rsp_hit, 0);
        @(negedge clk);
        look("R11 concurrent fill stored", mk(1, 9, 0), 1, 1, 'h900);
    endtask

    task automatic t_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        look("R1 miss after flush", mk(1, 5, 0), 0, 0, 0);
        look("R1 flush other set", mk(1, 1, 0), 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_six();
        t_branch();
        t_limits();
        t_tags();
        t_replace();
        t_stall();
        t_flush();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1..all actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule